// File: doc/BRIEF.md
# Dual-Domain Banked Interrupt Controller

This block gathers up to 64 level-or-pulse interrupt sources (49 by default) into two 32-bit register banks. Source n lives in bank n/32 at bit n mod 32 in every register. A per-source routing bit sends each source either to a system register set or to a user register set. Each set has its own enable, pending, software-set and acknowledge registers. A rising edge on a source marks it pending in the set it is routed to. The pending bit stays until software acknowledges it.

The block has one level output per source. Software uses a plain word-addressed register bus with separate read and write strobes. Read data comes back one clock after the read strobe. There is no arbitration between sources and no combined interrupt line: every output goes straight to its own consumer.

The default has one reserved source, number 35. Bank 1 bits 17 to 31 have no source behind them. These positions are inert in every register.

Top module: `banked_irq_ctrl`

## Requirements
- R1: Source n maps to bank n/32, bit n mod 32, in every register. A bank's registers sit at the base offset for bank 0 and at base+4 for bank 1.
- R2: Source 35 and bank 1 bits 17–31 read as 0 in every register and ignore writes. Their outputs and status never go high, even when their input pulses.
- R3: The byte offsets for bank 0 are: routing 0x08, system enable 0x10, system set 0x18, system acknowledge 0x20, system pending 0x28, user enable 0x40, user set 0x48, user acknowledge 0x50, user pending 0x58. Any other offset, including an offset not aligned to a word, reads 0 and ignores writes.
- R4: Routing and both enable registers are read/write. Writes to both pending registers have no effect. The set and acknowledge registers read as 0.
- R5: Writing 1 to an acknowledge bit clears that pending bit in its set. Writing 0 to an acknowledge bit leaves the pending bit unchanged.
- R6: Enable bit 1 unmasks a source and 0 masks it. Masking leaves the pending bit in place, and unmasking brings the output back.
- R7: Routing bit 1 selects the user set and 0 selects the system set. Changing the routing bit does not move pending bits that are already set.
- R8: Output n is high exactly while the pending bit AND the enable bit are both 1 in the set that source n is routed to. The output follows register changes in the same cycle.
- R9: A 0-to-1 change on a source input, sampled at a clock edge, sets its pending bit in the set selected at that edge. A source held high does not set the bit again after it has been acknowledged.
- R10: Writing 1 to a set-register bit forces the matching pending bit to 1 in that register set.
- R11: When a hardware edge and an acknowledge hit the same pending bit in the same cycle, the bit ends up set.
- R12: During reset and after reset, every register is 0 and every output is low.
- R13: bus_rdata takes the addressed value at the clock edge where bus_rd is high. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt source inputs, edge-detected |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | NUM_SRC | Per-source interrupt level outputs |

## Verification
A source edge and a software acknowledge of the same pending bit can land in the same cycle. The bench provokes this by driving the source's rising edge on the same falling clock edge that presents the acknowledge write. It also includes other pending bits in that write. The judgement is that the colliding bit stays pending while the other bits clear. A checker property also holds this for every bank and both sets whenever an acknowledge is written.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int BANK_W = 32;

    // Register group, taken from byte address bits [6:3]; bit [2] picks the bank
    typedef enum logic [3:0] {
        GRP_NONE     = 4'd0,
        GRP_ROUTE    = 4'd1,
        GRP_SYS_EN   = 4'd2,
        GRP_SYS_SET  = 4'd3,
        GRP_SYS_ACK  = 4'd4,
        GRP_SYS_PEND = 4'd5,
        GRP_USR_EN   = 4'd8,
        GRP_USR_SET  = 4'd9,
        GRP_USR_ACK  = 4'd10,
        GRP_USR_PEND = 4'd11
    } irqc_grp_e;

    typedef struct packed {
        logic route;
        logic sys_en;
        logic sys_set;
        logic sys_ack;
        logic usr_en;
        logic usr_set;
        logic usr_ack;
    } irqc_bank_wr_t;

    // Positions of a bank that carry a real source
    function automatic logic [BANK_W-1:0] bank_valid(int bank, int nsrc, int rsvd);
        logic [BANK_W-1:0] v;
        for (int i = 0; i < BANK_W; i++) begin
            int s;
            s = bank * BANK_W + i;
            v[i] = (s < nsrc) && (s != rsvd);
        end
        return v;
    endfunction

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int NUM_BANKS = 2
) (
    input  logic [ADDR_W-1:0]                    addr,
    input  logic                                 wr,
    output irqc_grp_e                            grp,
    output logic                                 bank_sel,
    output irqc_bank_wr_t [NUM_BANKS-1:0]        wr_strb
);

    logic in_map;

    assign in_map   = (addr[1:0] == 2'b00) && ((addr >> 7) == '0);
    assign bank_sel = addr[2];

    always_comb begin
        grp = GRP_NONE;
        if (in_map) begin
            unique case (addr[6:3])
                4'd1:    grp = GRP_ROUTE;
                4'd2:    grp = GRP_SYS_EN;
                4'd3:    grp = GRP_SYS_SET;
                4'd4:    grp = GRP_SYS_ACK;
                4'd5:    grp = GRP_SYS_PEND;
                4'd8:    grp = GRP_USR_EN;
                4'd9:    grp = GRP_USR_SET;
                4'd10:   grp = GRP_USR_ACK;
                4'd11:   grp = GRP_USR_PEND;
                default: grp = GRP_NONE;
            endcase
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_strb
        always_comb begin
            wr_strb[b] = '0;
            if (wr && (bank_sel == 1'(b))) begin
                unique case (grp)
                    GRP_ROUTE:   wr_strb[b].route   = 1'b1;
                    GRP_SYS_EN:  wr_strb[b].sys_en  = 1'b1;
                    GRP_SYS_SET: wr_strb[b].sys_set = 1'b1;
                    GRP_SYS_ACK: wr_strb[b].sys_ack = 1'b1;
                    GRP_USR_EN:  wr_strb[b].usr_en  = 1'b1;
                    GRP_USR_SET: wr_strb[b].usr_set = 1'b1;
                    GRP_USR_ACK: wr_strb[b].usr_ack = 1'b1;
                    default:     wr_strb[b] = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
#(
    parameter logic [BANK_W-1:0] VALID = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] src,
    input  irqc_bank_wr_t     we,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] route_q,
    output logic [BANK_W-1:0] sys_en_q,
    output logic [BANK_W-1:0] usr_en_q,
    output logic [BANK_W-1:0] sys_pend_q,
    output logic [BANK_W-1:0] usr_pend_q,
    output logic [BANK_W-1:0] irq
);

    logic [BANK_W-1:0] src_q;
    logic [BANK_W-1:0] rise;
    logic [BANK_W-1:0] wmask;
    logic [BANK_W-1:0] sys_set, usr_set, sys_ack, usr_ack;

    assign wmask = wdata & VALID;
    assign rise  = src & ~src_q & VALID;

    // Hardware edges use the routing in force before any same-cycle write
    always_comb begin
        sys_set = rise & ~route_q;
        usr_set = rise & route_q;
        if (we.sys_set) sys_set = sys_set | wmask;
        if (we.usr_set) usr_set = usr_set | wmask;
        sys_ack = we.sys_ack ? wmask : '0;
        usr_ack = we.usr_ack ? wmask : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q      <= '0;
            route_q    <= '0;
            sys_en_q   <= '0;
            usr_en_q   <= '0;
            sys_pend_q <= '0;
            usr_pend_q <= '0;
        end else begin
            src_q <= src;
            if (we.route)  route_q  <= wmask;
            if (we.sys_en) sys_en_q <= wmask;
            if (we.usr_en) usr_en_q <= wmask;
            // set after ack: a same-cycle set survives
            sys_pend_q <= ((sys_pend_q & ~sys_ack) | sys_set) & VALID;
            usr_pend_q <= ((usr_pend_q & ~usr_ack) | usr_set) & VALID;
        end
    end

    assign irq = (route_q & usr_pend_q & usr_en_q) | (~route_q & sys_pend_q & sys_en_q);

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_SRC  = 49,
    parameter int RSVD_SRC = 35,
    parameter int ADDR_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_SRC-1:0] irq_o
);

    localparam int NUM_BANKS = (NUM_SRC + BANK_W - 1) / BANK_W;
    localparam int TOT_W     = NUM_BANKS * BANK_W;

    irqc_grp_e                      grp;
    logic                           bank_sel;
    irqc_bank_wr_t [NUM_BANKS-1:0]  wr_strb;

    logic [TOT_W-1:0] src_pad;
    logic [NUM_BANKS-1:0][BANK_W-1:0] route_bk, sys_en_bk, usr_en_bk, sys_pend_bk, usr_pend_bk, irq_bk;
    logic [TOT_W-1:0] route_all, sstat_all, ustat_all, irq_all;
    logic [31:0]      rd_word;

    always_comb begin
        src_pad = '0;
        src_pad[NUM_SRC-1:0] = src_i;
    end

    irqc_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_decode (
        .addr     (bus_addr),
        .wr       (bus_wr),
        .grp      (grp),
        .bank_sel (bank_sel),
        .wr_strb  (wr_strb)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        irqc_bank #(.VALID(bank_valid(g, NUM_SRC, RSVD_SRC))) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .src        (src_pad[g*BANK_W +: BANK_W]),
            .we         (wr_strb[g]),
            .wdata      (bus_wdata),
            .route_q    (route_bk[g]),
            .sys_en_q   (sys_en_bk[g]),
            .usr_en_q   (usr_en_bk[g]),
            .sys_pend_q (sys_pend_bk[g]),
            .usr_pend_q (usr_pend_bk[g]),
            .irq        (irq_bk[g])
        );
    end

    assign route_all = route_bk;
    assign sstat_all = sys_pend_bk;
    assign ustat_all = usr_pend_bk;
    assign irq_all   = irq_bk;
    assign irq_o     = irq_all[NUM_SRC-1:0];

    always_comb begin
        unique case (grp)
            GRP_ROUTE:    rd_word = route_bk[bank_sel];
            GRP_SYS_EN:   rd_word = sys_en_bk[bank_sel];
            GRP_SYS_PEND: rd_word = sys_pend_bk[bank_sel];
            GRP_USR_EN:   rd_word = usr_en_bk[bank_sel];
            GRP_USR_PEND: rd_word = usr_pend_bk[bank_sel];
            default:      rd_word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
    end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int NUM_SRC  = 49,
    parameter int RSVD_SRC = 35,
    parameter int ADDR_W   = 7,
    parameter int TOT_W    = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        bus_rdata,
    input logic [NUM_SRC-1:0] irq_o,
    input logic [TOT_W-1:0]   irq_all,
    input logic [TOT_W-1:0]   route_all,
    input logic [TOT_W-1:0]   sstat_all,
    input logic [TOT_W-1:0]   ustat_all
);

    function automatic logic [TOT_W-1:0] all_valid();
        logic [TOT_W-1:0] v;
        for (int i = 0; i < TOT_W; i++) v[i] = (i < NUM_SRC) && (i != RSVD_SRC);
        return v;
    endfunction

    localparam logic [TOT_W-1:0] VALID = all_valid();

    logic [TOT_W-1:0] src_d, src_now, rise;
    logic [TOT_W-1:0] ack_sys, ack_usr;
    logic             plain_map, wo_hit, ack_hit;

    always_comb begin
        src_now = '0;
        src_now[NUM_SRC-1:0] = src_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_d <= '0;
        else        src_d <= src_now;
    end

    assign rise      = src_now & ~src_d & VALID;
    assign plain_map = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 7) == '0);
    assign wo_hit    = plain_map && (bus_addr[6:3] inside {4'd3, 4'd4, 4'd9, 4'd10});
    assign ack_hit   = bus_wr && plain_map && (bus_addr[6:3] inside {4'd4, 4'd10});

    always_comb begin
        ack_sys = '0;
        ack_usr = '0;
        if (bus_wr && plain_map && bus_addr[6:3] == 4'd4)
            ack_sys = TOT_W'(bus_wdata) << (bus_addr[2] ? 32 : 0);
        if (bus_wr && plain_map && bus_addr[6:3] == 4'd10)
            ack_usr = TOT_W'(bus_wdata) << (bus_addr[2] ? 32 : 0);
    end

    assert_unused_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_all | route_all | sstat_all | ustat_all) & ~VALID) == '0);

    assert_edge_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sstat_all & $past(rise & ~route_all)) == $past(rise & ~route_all)) &&
                 ((ustat_all & $past(rise & route_all)) == $past(rise & route_all)));

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && rise == '0 && !wo_hit_set()) |=>
            ((sstat_all & $past(ack_sys)) == '0) && ((ustat_all & $past(ack_usr)) == '0));

    assert_set_beats_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit |=> ((sstat_all & $past(rise & ~route_all & ack_sys)) == $past(rise & ~route_all & ack_sys)) &&
                    ((ustat_all & $past(rise & route_all & ack_usr)) == $past(rise & route_all & ack_usr)));

    assert_wo_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && wo_hit) |=> bus_rdata == '0);

    assert_fall_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(irq_o) & ~irq_o)) |-> $past(bus_wr));

    assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    assert_reset_quiet_R12: assert property (@(posedge clk)
        !rst_n |=> irq_o == '0);

    function automatic logic wo_hit_set();
        return 1'b0;
    endfunction

endmodule

bind banked_irq_ctrl irqc_checker #(
    .NUM_SRC (NUM_SRC),
    .RSVD_SRC(RSVD_SRC),
    .ADDR_W  (ADDR_W),
    .TOT_W   (TOT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .irq_all   (irq_all),
    .route_all (route_all),
    .sstat_all (sstat_all),
    .ustat_all (ustat_all)
);

// File: tb/banked_irq_ctrl_test.sv
module banked_irq_ctrl_test;

    localparam int NSRC = 49;
    localparam int RSVD = 35;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NSRC-1:0] src_i;
    logic [6:0]      bus_addr;
    logic            bus_wr, bus_rd;
    logic [31:0]     bus_wdata;
    logic [31:0]     bus_rdata;
    logic [NSRC-1:0] irq_o;

    always #5 clk = ~clk;

    banked_irq_ctrl #(.NUM_SRC(NSRC), .RSVD_SRC(RSVD), .ADDR_W(7)) uut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    function automatic logic [63:0] vmask();
        logic [63:0] v;
        for (int i = 0; i < 64; i++) v[i] = (i < NSRC) && (i != RSVD);
        return v;
    endfunction
    localparam logic [63:0] V = vmask();

    // bench model of the registers
    logic [63:0] m_route = '0, m_sen = '0, m_uen = '0, m_ss = '0, m_us = '0, lvl = '0;

    function automatic logic [63:0] exp_irq();
        return V & ((m_route & m_us & m_uen) | (~m_route & m_ss & m_sen));
    endfunction

    function automatic void model(input logic [6:0] a, input logic [31:0] d, input bit we, input logic [63:0] rise);
        logic [63:0] wv, ss, us, as, au;
        ss = rise & ~m_route & V;
        us = rise & m_route & V;
        as = '0; au = '0;
        wv = ({32'b0, d} << (a[2] ? 32 : 0)) & V;
        if (we && a[1:0] == 2'b00) begin
            case (a[6:3])
                4'd1:  m_route = (m_route & ~(64'hFFFFFFFF << (a[2] ? 32 : 0))) | wv;
                4'd2:  m_sen   = (m_sen   & ~(64'hFFFFFFFF << (a[2] ? 32 : 0))) | wv;
                4'd3:  ss = ss | wv;
                4'd4:  as = wv;
                4'd8:  m_uen   = (m_uen   & ~(64'hFFFFFFFF << (a[2] ? 32 : 0))) | wv;
                4'd9:  us = us | wv;
                4'd10: au = wv;
                default: ;
            endcase
        end
        m_ss = (m_ss & ~as) | ss;
        m_us = (m_us & ~au) | us;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [6:0] a);
        logic [63:0] r;
        r = '0;
        if (a[1:0] == 2'b00) begin
            case (a[6:3])
                4'd1:  r = m_route;
                4'd2:  r = m_sen;
                4'd5:  r = m_ss;
                4'd8:  r = m_uen;
                4'd11: r = m_us;
                default: r = '0;
            endcase
        end
        return a[2] ? r[63:32] : r[31:0];
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_src(input logic [6:0] a, input logic [31:0] d, input bit we, input logic [63:0] s);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = we; src_i = s[NSRC-1:0];
        @(negedge clk);
        bus_wr = 1'b0;
        model(a, d, we, s & ~lvl);
        lvl = s & {{(64-NSRC){1'b0}}, {NSRC{1'b1}}};
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        wr_src(a, d, 1'b1, lvl);
    endtask

    task automatic set_src(input logic [63:0] s);
        wr_src(7'h00, 32'h0, 1'b0, s);
    endtask

    task automatic rd_chk(input string tag, input logic [6:0] a);
        logic [31:0] e;
        e = exp_rd(a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk($sformatf("%s read 0x%02h", tag, a), {32'b0, bus_rdata}, {32'b0, e});
    endtask

    task automatic irq_chk(input string tag);
        chk($sformatf("%s irq_o", tag), {{(64-NSRC){1'b0}}, irq_o}, exp_irq());
    endtask

    task automatic all_chk(input string tag);
        irq_chk(tag);
        for (int b = 0; b < 2; b++) begin
            rd_chk(tag, 7'(8'h08 + 4*b));
            rd_chk(tag, 7'(8'h10 + 4*b));
            rd_chk(tag, 7'(8'h28 + 4*b));
            rd_chk(tag, 7'(8'h40 + 4*b));
            rd_chk(tag, 7'(8'h58 + 4*b));
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; src_i = '0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        // R12: outputs low during reset
        chk("R12 irq during reset", {15'b0, irq_o}, 64'h0);
        rst_n = 1'b1;
        // R12 / R4: every offset reads 0 after reset, write-only ones included
        for (int a = 0; a < 128; a += 4) rd_chk("R12", 7'(a));
        irq_chk("R12");

        // R4 / R2: read/write registers hold only implemented bits
        for (int b = 0; b < 2; b++) begin
            wr(7'(8'h08 + 4*b), 32'hFFFFFFFF);
            wr(7'(8'h10 + 4*b), 32'hFFFFFFFF);
            wr(7'(8'h40 + 4*b), 32'hA5A5A5A5);
            wr(7'(8'h28 + 4*b), 32'hFFFFFFFF); // pending is read-only
            wr(7'(8'h58 + 4*b), 32'hFFFFFFFF);
        end
        all_chk("R4 R2 rw");
        // R3: unmapped and misaligned writes are ignored
        wr(7'h00, 32'hFFFFFFFF); wr(7'h30, 32'hFFFFFFFF); wr(7'h61, 32'hFFFFFFFF);
        wr(7'h09, 32'h0); wr(7'h7C, 32'hFFFFFFFF);
        all_chk("R3 unmapped");
        rd_chk("R3 misaligned", 7'h0A);
        rd_chk("R3 gap", 7'h38);
        for (int b = 0; b < 2; b++) begin
            wr(7'(8'h08 + 4*b), 32'h0); wr(7'(8'h10 + 4*b), 32'h0); wr(7'(8'h40 + 4*b), 32'h0);
        end

        // R1 R7 R8 R9 R6 R5: sweep every source position
        for (int n = 0; n < NSRC; n++) begin
            bit usr;
            int b, bit_n;
            logic [6:0] en_a, ack_a;
            usr = ((n / 2) % 2) == 1;
            b = n / 32; bit_n = n % 32;
            en_a  = usr ? 7'(8'h40 + 4*b) : 7'(8'h10 + 4*b);
            ack_a = usr ? 7'(8'h50 + 4*b) : 7'(8'h20 + 4*b);
            wr(7'(8'h08 + 4*b), usr ? (32'h1 << bit_n) : 32'h0);
            wr(en_a, 32'h1 << bit_n);
            set_src(64'h1 << n);
            irq_chk($sformatf("R9 R8 R1 R7 src%0d", n));
            set_src(64'h0);
            wr(en_a, 32'h0);
            irq_chk($sformatf("R6 masked src%0d", n));
            rd_chk($sformatf("R6 pending kept src%0d", n), usr ? 7'(8'h58 + 4*b) : 7'(8'h28 + 4*b));
            wr(en_a, 32'h1 << bit_n);
            irq_chk($sformatf("R6 unmasked src%0d", n));
            wr(ack_a, ~(32'h1 << bit_n));
            irq_chk($sformatf("R5 ack zero src%0d", n));
            wr(ack_a, 32'h1 << bit_n);
            irq_chk($sformatf("R5 ack one src%0d", n));
            rd_chk($sformatf("R5 pending gone src%0d", n), usr ? 7'(8'h58 + 4*b) : 7'(8'h28 + 4*b));
            wr(en_a, 32'h0);
            wr(7'(8'h08 + 4*b), 32'h0);
        end

        // R10: software set into both register sets
        wr(7'h10, 32'hFFFFFFFF); wr(7'h44, 32'hFFFFFFFF);
        wr(7'h18, 32'h0000F00F);
        wr(7'h4C, 32'hFFFFFFFF);
        wr(7'h0C, 32'hFFFFFFFF);
        all_chk("R10 set");
        // R7: rerouting leaves pending bits where they were
        wr(7'h08, 32'h000000FF);
        wr(7'h0C, 32'h0);
        all_chk("R7 reroute");
        wr(7'h20, 32'hFFFFFFFF); wr(7'h24, 32'hFFFFFFFF);
        wr(7'h50, 32'hFFFFFFFF); wr(7'h54, 32'hFFFFFFFF);
        wr(7'h08, 32'h0);
        all_chk("R5 ack all");

        // R11: edge and acknowledge on the same bit in the same cycle
        wr(7'h18, 32'h000000F0);
        wr_src(7'h20, 32'hFFFFFFFF, 1'b1, 64'h20);
        all_chk("R11 sys collide");
        wr(7'h0C, 32'h00000001);
        wr(7'h44, 32'h00000001);
        wr(7'h4C, 32'h00000001);
        wr_src(7'h54, 32'hFFFFFFFF, 1'b1, 64'h1_0000_0020);
        all_chk("R11 usr collide");

        // R9: level held high does not re-set after acknowledge
        wr(7'h20, 32'hFFFFFFFF); wr(7'h54, 32'hFFFFFFFF);
        set_src(64'h1_0000_0020);
        set_src(64'h1_0000_0020);
        all_chk("R9 held level");
        set_src(64'h0);

        // R13: read data holds between reads
        rd_chk("R13 read", 7'h10);
        repeat (3) @(negedge clk);
        chk("R13 hold", {32'b0, bus_rdata}, {32'b0, exp_rd(7'h10)});

        done = 1;
        summary();
        $finish;
    end

endmodule